// File: doc/BRIEF.md
# UART Interrupt Priority Identification

This block sits between the status strobes of a UART's receiver, transmitter and FIFO logic and the register bus of the processor. It masks four interrupt sources with their enable bits, ranks the enabled ones by fixed priority, and presents the winner as a read-only identification word. A single interrupt output tells the processor that the word is worth reading.

The block has one register address. A read there returns the identification word. A write there loads the FIFO control byte, and bit 0 of that byte is the FIFO enable. Line-status, receive-data and timeout sources are levels that stay pending until the external logic withdraws them. The transmit-empty source is an event: a latch sets on the rising edge of the holding-register-empty status. The latch clears when a read returns the transmit-empty code or when the transmit holding register is written.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification word reads 0x01 (pending flag 1, type 0, FIFO bits 0), `irq` is 0 and `fifo_ctl` is 0.
- R2: An enabled line-status error wins over every other source and reports type 3h in bits 3..1, so the word reads 0x06 in non-FIFO mode.
- R3: Receive data ready reports type 2h (word 0x04) and ranks above transmit-empty. When data ready and character timeout are both pending, the type is 2h.
- R4: Character timeout alone reports type 6h (word 0x0C) and ranks above transmit-empty.
- R5: A rising edge on `tx_empty` sets the transmit-empty pending latch one clock later. On its own it reports type 1h (word 0x02), and it is the lowest priority.
- R6: A read of the identification word that returns type 1h clears the transmit-empty latch. A read that returns a higher-priority type leaves it pending.
- R7: A pulse on `thr_wr` clears the transmit-empty latch, and it stays clear while `tx_empty` stays high, until the next rising edge.
- R8: A source whose enable is 0 never clears the pending flag. `en_rx` gates both data ready and timeout, and with all enables 0 the word reads 0x01.
- R9: Line status, data ready and timeout are levels. Once the input drops, the source is no longer reported.
- R10: A bus write to the shared address loads `fifo_ctl` from `bus_wdata`. With `fifo_ctl[0]`=1, bits 7..6 of the word read 3h, and with it 0 they read 0. Bits 5..4 and 31..8 always read 0.
- R11: `irq` is always the inverse of bit 0 of the identification word.
- R12: `bus_rdata` is 0 unless `bus_rd` is high with `bus_addr` equal to the shared address. A write to any other address leaves `fifo_ctl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data (FIFO control byte) |
| bus_rdata | output | DATA_W (32) | Identification word while reading the shared address |
| line_err | input | 1 | Receiver line-status error level |
| rx_ready | input | 1 | Receive data ready level |
| char_tmo | input | 1 | Character timeout level |
| tx_empty | input | 1 | Transmit holding register empty status |
| thr_wr | input | 1 | Write pulse to the transmit holding register |
| en_line | input | 1 | Enable for line-status interrupts |
| en_rx | input | 1 | Enable for data-ready and timeout interrupts |
| en_tx | input | 1 | Enable for transmit-empty interrupts |
| fifo_ctl | output | 8 | FIFO control byte; bit 0 is the FIFO enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
Most internal faults show up in the identification word on the same cycle they occur. A wrong rank or code is visible as soon as two sources overlap, and a wrong mask is visible once a disabled source is held high. The transmit-empty latch is the one piece of hidden state. If it sets on a level instead of an edge, or if a read clears it when it should not, the fault appears only on the next read or on `irq` one clock later. The tests therefore hold `tx_empty` high across clears and read while a higher-priority source hides the latch.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        IT_NONE   = 3'h0,
        IT_TXMT   = 3'h1,
        IT_RXDATA = 3'h2,
        IT_LINE   = 3'h3,
        IT_TMO    = 3'h6
    } irq_type_e;

    typedef struct packed {
        logic line;
        logic rxrdy;
        logic tmo;
        logic txmt;
    } irq_src_t;

    typedef struct packed {
        logic line;
        logic rx;
        logic tx;
    } irq_en_t;

    typedef struct packed {
        logic [1:0] fifo_mode;
        logic [1:0] zero;
        irq_type_e  kind;
        logic       idle_n;
    } ident_byte_t;

    function automatic ident_byte_t build_ident(input logic fifo_on,
                                                input irq_type_e kind,
                                                input logic idle_n);
        ident_byte_t w;
        w.fifo_mode = fifo_on ? 2'b11 : 2'b00;
        w.zero      = 2'b00;
        w.kind      = kind;
        w.idle_n    = idle_n;
        return w;
    endfunction

endpackage

// File: rtl/uart_irq_fcr.sv
module uart_irq_fcr #(
    parameter int CTL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_q
);

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (wr_hit) ctl_q <= wdata;
    end

    // R10
    fcr_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> ctl_q == $past(wdata));

    // R12
    fcr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(ctl_q));

endmodule

// File: rtl/uart_irq_txmt.sv
module uart_irq_txmt (
    input  logic clk,
    input  logic rst,
    input  logic empty_lvl,
    input  logic thr_wr,
    input  logic ack_rd,
    output logic pending
);

    logic empty_d;
    logic empty_rise;

    assign empty_rise = empty_lvl && !empty_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_d <= 1'b0;
            pending <= 1'b0;
        end else begin
            empty_d <= empty_lvl;
            if (empty_rise)            pending <= 1'b1;
            else if (thr_wr || ack_rd) pending <= 1'b0;
        end
    end

    // R5
    txmt_set_chk: assert property (@(posedge clk) disable iff (rst)
        empty_rise |=> pending);

    // R7
    txmt_thr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !empty_rise) |=> !pending);

    // R7
    txmt_no_level_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!pending && $past(empty_lvl) && empty_lvl) |=> !pending);

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_src_t  src,
    input  irq_en_t   en,
    output irq_type_e kind,
    output logic      idle_n
);

    irq_src_t live;

    always_comb begin
        live.line  = src.line  && en.line;
        live.rxrdy = src.rxrdy && en.rx;
        live.tmo   = src.tmo   && en.rx;
        live.txmt  = src.txmt  && en.tx;
    end

    always_comb begin
        if (live.line)       kind = IT_LINE;
        else if (live.rxrdy) kind = IT_RXDATA;
        else if (live.tmo)   kind = IT_TMO;
        else if (live.txmt)  kind = IT_TXMT;
        else                 kind = IT_NONE;
        idle_n = (kind == IT_NONE);
    end

    // R8
    arb_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en == 3'b000) |-> idle_n);

    // R2
    arb_line_top_chk: assert property (@(posedge clk) disable iff (rst)
        (src.line && en.line) |-> (kind == IT_LINE));

    // R5
    arb_txmt_last_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == IT_TXMT) |-> !(src.line && en.line) && !(en.rx && (src.rxrdy || src.tmo)));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 32,
    parameter int IDENT_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              line_err,
    input  logic              rx_ready,
    input  logic              char_tmo,
    input  logic              tx_empty,
    input  logic              thr_wr,
    input  logic              en_line,
    input  logic              en_rx,
    input  logic              en_tx,
    output logic [7:0]        fifo_ctl,
    output logic              irq
);

    localparam int PAD_W = DATA_W - 8;
    localparam logic [ADDR_W-1:0] SHARED = ADDR_W'(IDENT_ADDR);

    logic        hit;
    logic        rd_hit;
    logic        txmt_pend;
    logic        txmt_ack;
    irq_src_t    src;
    irq_en_t     en;
    irq_type_e   kind;
    logic        idle_n;
    ident_byte_t word;

    assign hit    = (bus_addr == SHARED);
    assign rd_hit = bus_rd && hit;

    uart_irq_fcr #(.CTL_W(8)) u_fcr (
        .clk   (clk),
        .rst   (rst),
        .wr_hit(bus_wr && hit),
        .wdata (bus_wdata),
        .ctl_q (fifo_ctl)
    );

    assign txmt_ack = rd_hit && (kind == IT_TXMT);

    uart_irq_txmt u_txmt (
        .clk      (clk),
        .rst      (rst),
        .empty_lvl(tx_empty),
        .thr_wr   (thr_wr),
        .ack_rd   (txmt_ack),
        .pending  (txmt_pend)
    );

    always_comb begin
        src.line  = line_err;
        src.rxrdy = rx_ready;
        src.tmo   = char_tmo;
        src.txmt  = txmt_pend;
        en.line   = en_line;
        en.rx     = en_rx;
        en.tx     = en_tx;
    end

    uart_irq_arbiter u_arb (
        .clk   (clk),
        .rst   (rst),
        .src   (src),
        .en    (en),
        .kind  (kind),
        .idle_n(idle_n)
    );

    assign word      = build_ident(fifo_ctl[0], kind, idle_n);
    assign bus_rdata = rd_hit ? {{PAD_W{1'b0}}, word} : '0;
    assign irq       = !idle_n;

    // R11
    irq_matches_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> (bus_rdata[0] == !irq));

    // R10
    fifo_bits_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> (bus_rdata[7:6] == {2{fifo_ctl[0]}}) && (bus_rdata[5:4] == 2'b00));

    // R6
    read_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && bus_rdata[3:1] == 3'h1 && !thr_wr && !$rose(tx_empty)) |=> !irq || !(bus_rdata[3:1] == 3'h1) || !rd_hit);

    // R12
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> (bus_rdata == '0));

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] IDA = 3'd2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              line_err = 0, rx_ready = 0, char_tmo = 0, tx_empty = 0, thr_wr = 0;
    logic              en_line = 0, en_rx = 0, en_tx = 0;
    logic [7:0]        fifo_ctl;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    uart_irq_ident #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDENT_ADDR(2)) u_uart_irq_ident (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_err(line_err),
        .rx_ready(rx_ready), .char_tmo(char_tmo), .tx_empty(tx_empty), .thr_wr(thr_wr),
        .en_line(en_line), .en_rx(en_rx), .en_tx(en_tx), .fifo_ctl(fifo_ctl), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one read cycle at the given address; word sampled mid-cycle
    task automatic rd_at(input logic [ADDR_W-1:0] a, output logic [31:0] w, output logic irq_seen);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        w = bus_rdata; irq_seen = irq;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_word(output logic [31:0] w);
        logic i;
        rd_at(IDA, w, i);
        checks++;
        if (i !== !w[0]) begin
            fails++;
            $display("FAIL R11 actual irq=%0b expected=%0b", i, !w[0]);
        end
    endtask

    task automatic wr_at(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        line_err = 0; rx_ready = 0; char_tmo = 0; tx_empty = 0;
        en_line = 1; en_rx = 1; en_tx = 1;
        thr_wr = 1;
        @(negedge clk);
        thr_wr = 0;
    endtask

    task automatic t_reset();
        logic [31:0] w;
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 fifo_ctl", {24'b0, fifo_ctl}, 32'h0);
        rd_word(w);
        check("R1 word", w, 32'h01);
    endtask

    task automatic t_priority();
        logic [31:0] w;
        clear_all();
        @(negedge clk); tx_empty = 1; rx_ready = 1; char_tmo = 1; line_err = 1;
        @(negedge clk);
        rd_word(w); check("R2 line wins", w, 32'h06);
        line_err = 0;
        rd_word(w); check("R3 rx and tmo give 2h", w, 32'h04);
        rx_ready = 0;
        rd_word(w); check("R4 tmo over txmt", w, 32'h0C);
        char_tmo = 0;
        rd_word(w); check("R5 txmt lowest", w, 32'h02);
        rd_word(w); check("R6 read cleared txmt", w, 32'h01);
    endtask

    task automatic t_hidden_read();
        logic [31:0] w;
        clear_all();
        @(negedge clk); tx_empty = 1; line_err = 1;
        @(negedge clk);
        rd_word(w); check("R6 line shown", w, 32'h06);
        line_err = 0;
        rd_word(w); check("R6 txmt survives hidden read", w, 32'h02);
        check("R11 irq low after ack", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_thr_write();
        logic [31:0] w;
        clear_all();
        @(negedge clk); tx_empty = 1;
        @(negedge clk);
        check("R5 irq after edge", {31'b0, irq}, 32'h1);
        thr_wr = 1;
        @(negedge clk); thr_wr = 0;
        repeat (3) @(negedge clk);
        check("R7 stays clear while high", {31'b0, irq}, 32'h0);
        rd_word(w); check("R7 word clear", w, 32'h01);
        tx_empty = 0;
        @(negedge clk); tx_empty = 1;
        @(negedge clk);
        rd_word(w); check("R7 new edge sets", w, 32'h02);
    endtask

    task automatic t_mask();
        logic [31:0] w;
        clear_all();
        @(negedge clk); en_line = 0; en_rx = 0; en_tx = 0;
        line_err = 1; rx_ready = 1; char_tmo = 1; tx_empty = 1;
        @(negedge clk);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        rd_word(w); check("R8 all masked", w, 32'h01);
        en_tx = 1;
        @(negedge clk);
        rd_word(w); check("R8 rx gated, txmt shows", w, 32'h02);
        en_rx = 1;
        rx_ready = 0;
        @(negedge clk);
        rd_word(w); check("R8 en_rx gates tmo", w, 32'h0C);
        char_tmo = 0; line_err = 0;
    endtask

    task automatic t_levels();
        logic [31:0] w;
        clear_all();
        @(negedge clk); line_err = 1;
        @(negedge clk);
        rd_word(w); check("R9 line held", w, 32'h06);
        rd_word(w); check("R9 line still held", w, 32'h06);
        line_err = 0;
        #1;
        check("R9 irq drops with level", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_fifo();
        logic [31:0] w;
        logic i;
        clear_all();
        wr_at(IDA, 8'hC1);
        check("R10 fifo_ctl loaded", {24'b0, fifo_ctl}, 32'hC1);
        rd_word(w); check("R10 fifo bits set", w, 32'hC1);
        @(negedge clk); rx_ready = 1;
        rd_word(w); check("R10 fifo and rx", w, 32'hC4);
        rx_ready = 0;
        wr_at(3'd5, 8'h00);
        check("R12 other addr write ignored", {24'b0, fifo_ctl}, 32'hC1);
        @(negedge clk); rx_ready = 1;
        rd_at(3'd1, w, i);
        check("R12 other addr read zero", w, 32'h0);
        rx_ready = 0;
        wr_at(IDA, 8'h06);
        rd_word(w); check("R10 fifo bits clear", w, 32'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_priority();
        t_hidden_read();
        t_thr_write();
        t_mask();
        t_levels();
        t_fifo();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule